// File: doc/BRIEF.md
# Serial Calibration DAC Loader

This block turns one parallel write (a channel number and an 8-bit trim code) into an 11-bit serial frame for an eight-channel calibration DAC. It drives three lines: serial data, a shift clock and a load strobe. The three-bit channel number goes out first, most significant bit first, followed by the code, also most significant bit first. Each data bit is held for one bit period of `BIT_CYCLES` clock cycles. The shift clock rises once in the middle of each bit period. When all 11 bits have been sent, the load strobe goes high for one bit period with data and clock low. After that, all three lines return low.

A host raises `start` with a channel and code. The block accepts the request only while `busy` is low. It holds `busy` high for the whole frame and ignores further requests until the frame is done. A channel number of 8 or more produces a one-cycle `err` pulse, and the block sends nothing for it. For every accepted write, the block keeps a shadow copy of the code for that channel, and the host can read any copy back at any time through a separate combinational read port.

Top module: `cal_dac_serializer`

## Requirements
- R1: An accepted frame is 11 bits long: the channel number in frame bits 10..8 and the code in bits 7..0. It is sent starting with frame bit 10 (channel bit 2) and ending with frame bit 0 (code bit 0).
- R2: Each frame bit appears on `sdata` for exactly `BIT_CYCLES` consecutive clocks, starting in the cycle after `start` is accepted. `sload` stays low while the data bits are sent.
- R3: `sdata` changes only at the boundary between bit periods.
- R4: `sclk` is low for the first `BIT_CYCLES/2` cycles of each data bit period and high for the rest, which gives exactly one rising edge per data bit.
- R5: After the last data bit, `sload` is high for exactly `BIT_CYCLES` cycles with `sdata` and `sclk` low. After that, all three lines are low.
- R6: A `start` while idle with `addr` of 8 or more raises `err` for exactly the next cycle. For such a request the block sends no frame, keeps `busy` low and leaves every shadow value unchanged.
- R7: `busy` is high for exactly 12*`BIT_CYCLES` cycles per accepted frame. A `start` seen while `busy` is high has no effect on the frame, the lines or the shadow values.
- R8: `rd_code` shows the code last accepted for channel `rd_addr`. A new value is visible from the cycle after acceptance.
- R9: A synchronous reset (`rst` high at a clock edge) stops any frame in progress. It drives `busy`, `err`, `sdata`, `sclk` and `sload` low and clears all eight shadow values to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Write request, accepted when `busy` is low |
| addr | input | 4 | Requested channel; values 8..15 are illegal |
| code | input | 8 | Trim code to send |
| rd_addr | input | 3 | Channel selected for shadow readback |
| busy | output | 1 | Frame in progress |
| err | output | 1 | One-cycle pulse after an illegal channel request |
| sdata | output | 1 | Serial data line |
| sclk | output | 1 | Shift clock, rising mid-bit |
| sload | output | 1 | Load strobe after the last bit |
| rd_code | output | 8 | Shadow code of channel `rd_addr` |

## Verification
The assertions check on every cycle that:
- all three lines are low while idle;
- data and clock are low during the load strobe;
- data holds steady inside a bit period;
- each clock rise falls at the half-period point;
- an error pulse never coincides with a frame.

Only the bench's cycle-by-cycle reference model can show the rest. That covers the bit order and content of each frame, the exact busy length, requests ignored in mid-frame or at its last cycle, a request accepted in the first cycle after a frame, rejection of channels 8 and 15 without any change to the readback, and shadow clearing on a reset that cuts a frame short.

// File: rtl/cal_dac_serializer.sv
module cal_dac_serializer #(
  parameter int BIT_CYCLES = 4,
  parameter int NUM_CH     = 8,
  parameter int CODE_W     = 8,
  parameter int ADDR_IN_W  = 4,
  parameter int SEL_W      = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_IN_W-1:0] addr,
  input  logic [CODE_W-1:0]    code,
  input  logic [SEL_W-1:0]     rd_addr,
  output logic                 busy,
  output logic                 err,
  output logic                 sdata,
  output logic                 sclk,
  output logic                 sload,
  output logic [CODE_W-1:0]    rd_code
);
  localparam int FRAME_W = SEL_W + CODE_W;
  localparam int CNT_W   = $clog2(BIT_CYCLES);
  localparam int BIDX_W  = $clog2(FRAME_W + 1);
  localparam int HALF    = BIT_CYCLES / 2;

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic [BIDX_W-1:0]  bidx;
  logic               active;
  logic               err_q;
  logic [CODE_W-1:0]  shadow [NUM_CH];

  wire last_tick = (cnt == CNT_W'(BIT_CYCLES - 1));
  wire in_load   = (bidx == BIDX_W'(FRAME_W));
  wire legal     = (addr < ADDR_IN_W'(NUM_CH));
  wire accept    = start && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      err_q  <= 1'b0;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      for (int i = 0; i < NUM_CH; i++) shadow[i] <= '0;
    end else begin
      err_q <= accept && !legal;
      if (accept && legal) begin
        active <= 1'b1;
        cnt    <= '0;
        bidx   <= '0;
        sh     <= {addr[SEL_W-1:0], code};
        shadow[addr[SEL_W-1:0]] <= code;
      end else if (active) begin
        if (last_tick) begin
          cnt <= '0;
          if (in_load) begin
            active <= 1'b0;
          end else begin
            bidx <= bidx + BIDX_W'(1);
            sh   <= {sh[FRAME_W-2:0], 1'b0};
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign busy    = active;
  assign err     = err_q;
  assign sdata   = active && !in_load && sh[FRAME_W-1];
  assign sclk    = active && !in_load && (cnt >= CNT_W'(HALF));
  assign sload   = active && in_load;
  assign rd_code = shadow[rd_addr];

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sdata && !sclk && !sload));

  assert_strobe_alone_R5: assert property (@(posedge clk) disable iff (rst)
    sload |-> (!sdata && !sclk));

  assert_data_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |-> $stable(sdata));

  assert_clock_midbit_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (cnt == CNT_W'(HALF)));

  assert_reject_no_frame_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !err);
endmodule

// File: tb/sim_cal_dac_serializer.sv
module sim_cal_dac_serializer;
  localparam int DIV = 4;
  localparam int FW  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] code = '0;
  logic [2:0] rd_addr = '0;
  wire busy, err, sdata, sclk, sload;
  wire [7:0] rd_code;

  always #2.5 clk = ~clk;

  cal_dac_serializer #(.BIT_CYCLES(DIV)) u0 (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .code(code),
    .rd_addr(rd_addr), .busy(busy), .err(err), .sdata(sdata),
    .sclk(sclk), .sload(sload), .rd_code(rd_code)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [3:0] q[$];
  logic [3:0] cur = '0;
  logic [7:0] model_sh [8];
  logic exp_err = 1'b0;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic s, input logic [3:0] a, input logic [7:0] c, input logic r);
    logic was_busy;
    logic [10:0] frame;
    start = s; addr = a; code = c; rst = r; rd_addr = cyc[2:0];
    @(posedge clk); #1;
    cyc++;
    if (r) begin
      q.delete(); cur = '0; exp_err = 1'b0;
      for (int i = 0; i < 8; i++) model_sh[i] = '0;
    end else begin
      was_busy = cur[3];
      exp_err = s && !was_busy && (a >= 4'd8);
      if (q.size() > 0) cur = q.pop_front(); else cur = '0;
      if (s && !was_busy && (a < 4'd8)) begin
        model_sh[a[2:0]] = c;
        frame = {a[2:0], c};
        for (int b = FW - 1; b >= 0; b--)
          for (int k = 0; k < DIV; k++)
            q.push_back({1'b1, 1'b0, (k >= DIV / 2), frame[b]});
        for (int k = 0; k < DIV; k++) q.push_back(4'b1100);
        cur = q.pop_front();
      end
    end
    chk(r ? "R9" : "R2", "sdata", {7'd0, sdata}, {7'd0, cur[0]});
    chk(r ? "R9" : "R4", "sclk",  {7'd0, sclk},  {7'd0, cur[1]});
    chk(r ? "R9" : "R5", "sload", {7'd0, sload}, {7'd0, cur[2]});
    chk(r ? "R9" : "R7", "busy",  {7'd0, busy},  {7'd0, cur[3]});
    chk(r ? "R9" : "R6", "err",   {7'd0, err},   {7'd0, exp_err});
    chk(r ? "R9" : "R8", "rd_code", rd_code, model_sh[rd_addr]);
  endtask

  task automatic send(input logic [3:0] a, input logic [7:0] c);
    step(1'b1, a, c, 1'b0);
    while (cur[3]) step(1'b0, 4'd0, 8'd0, 1'b0);
  endtask

  task automatic send_hold(input logic [3:0] a, input logic [7:0] c, input logic [3:0] a2, input logic [7:0] c2);
    step(1'b1, a, c, 1'b0);
    while (cur[3]) step(1'b1, a2, c2, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 8'd0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model_sh[i] = '0;
    step(1'b0, 4'd0, 8'd0, 1'b1);               // R9 reset state
    step(1'b0, 4'd0, 8'd0, 1'b1);
    idle(3);
    send(4'd0, 8'hA5);                          // R1 R2 R4 R5 pattern 1
    idle(2);
    send_hold(4'd7, 8'h3C, 4'd2, 8'h99);        // R7 start held through frame
    step(1'b1, 4'd3, 8'h00, 1'b0);              // R7 accepted right after busy drops
    while (cur[3]) step(1'b0, 4'd0, 8'd0, 1'b0);
    step(1'b1, 4'd8, 8'h11, 1'b0);              // R6 illegal channel 8
    idle(2);
    step(1'b1, 4'd15, 8'h22, 1'b0);             // R6 illegal channel 15, repeated
    step(1'b1, 4'd15, 8'h22, 1'b0);
    idle(8);                                    // R8 readback sweep
    send(4'd5, 8'hFF);
    send(4'd6, 8'h01);
    idle(8);
    step(1'b1, 4'd1, 8'h5A, 1'b0);              // R9 reset cuts frame short
    idle(17);
    step(1'b0, 4'd0, 8'd0, 1'b1);
    idle(9);
    send(4'd2, 8'h80);                          // R3 single set bit
    idle(8);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule